// File: doc/BRIEF.md
# Hierarchical Route and Virtual-Channel Selector

This block is the route-computation stage of one router in a hierarchical on-chip network. Each core has a four-level address: group, cluster, tile and processor. A router sits on one tile and serves that tile's processors. The tiles of a cluster share one channel. Clusters inside a group are joined by point-to-point wireless links, and these links end on fixed corner tiles. In the large layout, groups are joined by wireless links that reach every cluster of the target group at the same time.

The block receives the router's own position and a packet's destination. From them it picks one of four actions:
- eject the packet to a local processor,
- send it on the shared channel toward a tile,
- send it over a cluster wireless link,
- send it over a group wireless link.

It also reports the next-hop tile and the set of virtual channels the packet may use, which keeps traffic classes apart and so avoids deadlock. A frame that arrived on a group link at a cluster that is not its destination is flagged to be dropped. The decision is computed combinationally and then held in one register stage. The `LARGE` parameter selects the 256-core layout (0) or the 1024-core layout (1).

Top module: `rtr_route_sel`

## Requirements
- R1: Reset clears `out_valid`, `out_port`, `out_tile`, `out_vc` and `out_drop` to zero. `out_valid` is `in_valid` delayed by exactly one clock, and the other outputs describe the input of that same cycle.
- R2: If the destination cluster and tile equal the router's own (and the group too, in the large layout), the result is port = `dst_proc` (ports 0..3 are the local processors), `out_tile` = own tile and `out_vc` = 0000.
- R3: If the destination is in the own cluster but on another tile, the result is a shared-channel port = 4 + dt when dt < own tile, or 3 + dt when dt > own tile (range 4..18). `out_tile` = dt.
- R4: If the destination is in another cluster of the own group and the router is not on the gateway tile for that cluster pair, the packet goes on the shared channel (port encoded as in R3) with `out_tile` = the gateway tile. Gateway corners are A = tile 0, B = tile 3, C = tile 12, D = tile 15 (D is never used as a gateway). The corner each cluster uses toward each other cluster is:

  | From \ To | 0 | 1 | 2 | 3 |
  |---|---|---|---|---|
  | 0 | – | B | A | C |
  | 1 | A | – | C | B |
  | 2 | B | C | – | A |
  | 3 | C | A | B | – |

- R5: On the gateway tile for the destination cluster, the result is port 19 (the cluster wireless link) with `out_tile` = the peer cluster's gateway tile toward this cluster.
- R6: In the 256-core layout, shared-channel hops get `out_vc` = 0011 and cluster wireless hops get 1100. The group fields and `in_from_grp` have no effect on any output.
- R7: In the large layout with a different group, the direction code is own group XOR destination group: 01 horizontal, 10 vertical, 11 diagonal. The exit corner is A for vertical, B for horizontal and C for diagonal. On that tile the result is port 20 (the group wireless link) with `out_tile` = the same corner tile. On any other tile the packet goes on the shared channel toward that corner.
- R8: In the large layout, every hop inside the destination group gets `out_vc` 0001, except ejection, which keeps 0000. Hops toward another group get 0010 for vertical, 0100 for horizontal and 1000 for diagonal.
- R9: In the large layout, a frame with `in_from_grp` = 1 whose destination group equals the own group but whose destination cluster differs sets `out_drop` = 1, with port, tile and vc all zero. If the cluster matches, the frame is routed normally with `out_drop` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A destination is presented this cycle |
| in_from_grp | input | 1 | The frame arrived on a group wireless link |
| my_grp | input | 2 | Own group |
| my_clu | input | 2 | Own cluster |
| my_tile | input | 4 | Own tile |
| dst_grp | input | 2 | Destination group |
| dst_clu | input | 2 | Destination cluster |
| dst_tile | input | 4 | Destination tile |
| dst_proc | input | 2 | Destination processor |
| out_valid | output | 1 | The registered decision is valid |
| out_port | output | 5 | Chosen output port |
| out_tile | output | 4 | Next-hop tile |
| out_vc | output | 4 | Allowed virtual-channel mask |
| out_drop | output | 1 | Discard this multicast copy |

## Verification
A wrong entry in the gateway corner table shows up one clock after the input as a wrong `out_tile` or a wrong choice between port 19 and a shared port, but only for the cluster pair whose entry is wrong. For that reason, every ordered pair of clusters is driven from both the gateway tile and a non-gateway tile. A wrong direction decode or VC class shows up in the same cycle as an `out_vc` that is not one-hot, or as the wrong class bit. A broken drop condition is exposed by multicast frames whose destination cluster either matches or differs from the receiving cluster.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

    localparam int GRP_W = 2;
    localparam int CLU_W = 2;
    localparam int VC_N  = 4;

    typedef enum logic [1:0] {
        CORNER_A = 2'd0,
        CORNER_B = 2'd1,
        CORNER_C = 2'd2,
        CORNER_D = 2'd3
    } corner_e;

    // Direction code equals the XOR of two group numbers.
    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_HORZ = 2'd1,
        DIR_VERT = 2'd2,
        DIR_DIAG = 2'd3
    } gdir_e;

    typedef enum logic [2:0] {
        HOP_EJECT  = 3'd0,
        HOP_SHARED = 3'd1,
        HOP_CLU    = 3'd2,
        HOP_GRP    = 3'd3,
        HOP_DROP   = 3'd4
    } hop_e;

    typedef struct packed {
        hop_e  hop;
        gdir_e dir;
    } hop_dec_t;

    // Corner a cluster uses toward another cluster of its group.
    function automatic corner_e pair_corner(input logic [CLU_W-1:0] src,
                                            input logic [CLU_W-1:0] dst);
        corner_e c;
        case ({src, dst})
            4'b00_01: c = CORNER_B;
            4'b00_10: c = CORNER_A;
            4'b00_11: c = CORNER_C;
            4'b01_00: c = CORNER_A;
            4'b01_10: c = CORNER_C;
            4'b01_11: c = CORNER_B;
            4'b10_00: c = CORNER_B;
            4'b10_01: c = CORNER_C;
            4'b10_11: c = CORNER_A;
            4'b11_00: c = CORNER_C;
            4'b11_01: c = CORNER_A;
            4'b11_10: c = CORNER_B;
            default:  c = CORNER_D;
        endcase
        return c;
    endfunction

    // Exit corner used for a group-to-group direction.
    function automatic corner_e dir_corner(input gdir_e d);
        corner_e c;
        case (d)
            DIR_VERT: c = CORNER_A;
            DIR_HORZ: c = CORNER_B;
            default:  c = CORNER_C;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rtr_hop_decide.sv
module rtr_hop_decide
    import rtr_pkg::*;
#(
    parameter bit LARGE  = 1'b1,
    parameter int TILES  = 16,
    parameter int TILE_A = 0,
    parameter int TILE_B = 3,
    parameter int TILE_C = 12,
    parameter int TILE_D = 15,
    localparam int TILE_W = $clog2(TILES)
) (
    input  logic               from_grp,
    input  logic [GRP_W-1:0]   my_grp,
    input  logic [CLU_W-1:0]   my_clu,
    input  logic [TILE_W-1:0]  my_tile,
    input  logic [GRP_W-1:0]   dst_grp,
    input  logic [CLU_W-1:0]   dst_clu,
    input  logic [TILE_W-1:0]  dst_tile,
    output hop_dec_t           dec,
    output logic [TILE_W-1:0]  tgt_tile
);

    function automatic logic [TILE_W-1:0] corner_tile(input corner_e c);
        logic [TILE_W-1:0] t;
        case (c)
            CORNER_A: t = TILE_W'(TILE_A);
            CORNER_B: t = TILE_W'(TILE_B);
            CORNER_C: t = TILE_W'(TILE_C);
            default:  t = TILE_W'(TILE_D);
        endcase
        return t;
    endfunction

    gdir_e             dir;
    logic [TILE_W-1:0] own_gw;
    logic [TILE_W-1:0] peer_gw;
    logic [TILE_W-1:0] exit_gw;

    generate
        if (LARGE) begin : g_large
            assign dir = gdir_e'(my_grp ^ dst_grp);
        end else begin : g_small
            assign dir = DIR_NONE;
        end
    endgenerate

    assign own_gw  = corner_tile(pair_corner(my_clu, dst_clu));
    assign peer_gw = corner_tile(pair_corner(dst_clu, my_clu));
    assign exit_gw = corner_tile(dir_corner(dir));

    always_comb begin
        dec.dir  = dir;
        dec.hop  = HOP_EJECT;
        tgt_tile = my_tile;
        if (LARGE && from_grp && dir == DIR_NONE && dst_clu != my_clu) begin
            dec.hop  = HOP_DROP;
            tgt_tile = '0;
        end else if (dir != DIR_NONE) begin
            dec.hop  = (my_tile == exit_gw) ? HOP_GRP : HOP_SHARED;
            tgt_tile = exit_gw;
        end else if (dst_clu != my_clu) begin
            if (my_tile == own_gw) begin
                dec.hop  = HOP_CLU;
                tgt_tile = peer_gw;
            end else begin
                dec.hop  = HOP_SHARED;
                tgt_tile = own_gw;
            end
        end else if (dst_tile != my_tile) begin
            dec.hop  = HOP_SHARED;
            tgt_tile = dst_tile;
        end
    end

endmodule

// File: rtl/rtr_port_sel.sv
module rtr_port_sel
    import rtr_pkg::*;
#(
    parameter int PROCS = 4,
    parameter int TILES = 16,
    localparam int TILE_W   = $clog2(TILES),
    localparam int PROC_W   = $clog2(PROCS),
    localparam int PORT_W   = $clog2(PROCS + TILES + 1),
    localparam int CLU_PORT = PROCS + TILES - 1,
    localparam int GRP_PORT = PROCS + TILES
) (
    input  hop_e               hop,
    input  logic [TILE_W-1:0]  my_tile,
    input  logic [TILE_W-1:0]  tgt_tile,
    input  logic [PROC_W-1:0]  dst_proc,
    output logic [PORT_W-1:0]  port
);

    logic [PORT_W-1:0] shared_port;

    // Own tile has no shared port, so tiles above it shift down by one.
    assign shared_port = PORT_W'(PROCS) + PORT_W'(tgt_tile)
                       - PORT_W'(tgt_tile > my_tile);

    always_comb begin
        case (hop)
            HOP_EJECT:  port = PORT_W'(dst_proc);
            HOP_SHARED: port = shared_port;
            HOP_CLU:    port = PORT_W'(CLU_PORT);
            HOP_GRP:    port = PORT_W'(GRP_PORT);
            default:    port = '0;
        endcase
    end

endmodule

// File: rtl/rtr_vc_sel.sv
module rtr_vc_sel
    import rtr_pkg::*;
#(
    parameter bit LARGE = 1'b1
) (
    input  hop_dec_t          dec,
    output logic [VC_N-1:0]   vc
);

    generate
        if (LARGE) begin : g_large
            always_comb begin
                if (dec.hop == HOP_EJECT || dec.hop == HOP_DROP) begin
                    vc = '0;
                end else begin
                    case (dec.dir)
                        DIR_VERT: vc = 4'b0010;
                        DIR_HORZ: vc = 4'b0100;
                        DIR_DIAG: vc = 4'b1000;
                        default:  vc = 4'b0001;
                    endcase
                end
            end
        end else begin : g_small
            always_comb begin
                case (dec.hop)
                    HOP_SHARED: vc = 4'b0011;
                    HOP_CLU:    vc = 4'b1100;
                    default:    vc = 4'b0000;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/rtr_route_sel.sv
module rtr_route_sel
    import rtr_pkg::*;
#(
    parameter bit LARGE  = 1'b1,
    parameter int PROCS  = 4,
    parameter int TILES  = 16,
    parameter int TILE_A = 0,
    parameter int TILE_B = 3,
    parameter int TILE_C = 12,
    parameter int TILE_D = 15,
    localparam int TILE_W = $clog2(TILES),
    localparam int PROC_W = $clog2(PROCS),
    localparam int PORT_W = $clog2(PROCS + TILES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_from_grp,
    input  logic [GRP_W-1:0]   my_grp,
    input  logic [CLU_W-1:0]   my_clu,
    input  logic [TILE_W-1:0]  my_tile,
    input  logic [GRP_W-1:0]   dst_grp,
    input  logic [CLU_W-1:0]   dst_clu,
    input  logic [TILE_W-1:0]  dst_tile,
    input  logic [PROC_W-1:0]  dst_proc,
    output logic               out_valid,
    output logic [PORT_W-1:0]  out_port,
    output logic [TILE_W-1:0]  out_tile,
    output logic [VC_N-1:0]    out_vc,
    output logic               out_drop
);

    hop_dec_t          dec;
    logic [TILE_W-1:0] tgt_tile;
    logic [PORT_W-1:0] port_c;
    logic [VC_N-1:0]   vc_c;

    rtr_hop_decide #(
        .LARGE(LARGE), .TILES(TILES),
        .TILE_A(TILE_A), .TILE_B(TILE_B), .TILE_C(TILE_C), .TILE_D(TILE_D)
    ) hop_i (
        .from_grp(in_from_grp),
        .my_grp(my_grp), .my_clu(my_clu), .my_tile(my_tile),
        .dst_grp(dst_grp), .dst_clu(dst_clu), .dst_tile(dst_tile),
        .dec(dec), .tgt_tile(tgt_tile)
    );

    rtr_port_sel #(.PROCS(PROCS), .TILES(TILES)) port_i (
        .hop(dec.hop), .my_tile(my_tile), .tgt_tile(tgt_tile),
        .dst_proc(dst_proc), .port(port_c)
    );

    rtr_vc_sel #(.LARGE(LARGE)) vc_i (
        .dec(dec), .vc(vc_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_tile  <= '0;
            out_vc    <= '0;
            out_drop  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_port  <= port_c;
            out_tile  <= tgt_tile;
            out_vc    <= vc_c;
            out_drop  <= (dec.hop == HOP_DROP);
        end
    end

endmodule

// File: rtl/rtr_route_chk.sv
module rtr_route_chk
    import rtr_pkg::*;
#(
    parameter bit LARGE = 1'b1,
    parameter int PROCS = 4,
    parameter int TILES = 16,
    localparam int TILE_W = $clog2(TILES),
    localparam int PROC_W = $clog2(PROCS),
    localparam int PORT_W = $clog2(PROCS + TILES + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_from_grp,
    input logic [GRP_W-1:0]   my_grp,
    input logic [CLU_W-1:0]   my_clu,
    input logic [TILE_W-1:0]  my_tile,
    input logic [GRP_W-1:0]   dst_grp,
    input logic [CLU_W-1:0]   dst_clu,
    input logic [TILE_W-1:0]  dst_tile,
    input logic [PROC_W-1:0]  dst_proc,
    input logic               out_valid,
    input logic [PORT_W-1:0]  out_port,
    input logic [TILE_W-1:0]  out_tile,
    input logic [VC_N-1:0]    out_vc,
    input logic               out_drop
);

    localparam int SH_LO    = PROCS;
    localparam int SH_HI    = PROCS + TILES - 2;
    localparam int GRP_PORT = PROCS + TILES;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    eject_here_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_drop || int'(out_port) >= PROCS
                      || (out_tile == $past(my_tile) && out_vc == '0)));

    // R3
    shared_not_self_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (int'(out_port) < SH_LO || int'(out_port) > SH_HI
                      || out_tile != $past(my_tile)));

    // R8
    vc_class_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (LARGE ? $onehot0(out_vc)
                             : (out_vc == 4'b0000 || out_vc == 4'b0011
                                || out_vc == 4'b1100)));

    // R9
    drop_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_drop) |-> (out_port == '0 && out_vc == '0
                                     && out_tile == '0));

    // R6
    small_no_group_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !LARGE) |-> (!out_drop && int'(out_port) != GRP_PORT));

endmodule

bind rtr_route_sel rtr_route_chk #(
    .LARGE(LARGE), .PROCS(PROCS), .TILES(TILES)
) chk_i (.*);

// File: tb/rtr_route_sel_tb.sv
module rtr_route_sel_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_from_grp;
    logic [1:0] my_grp, my_clu, dst_grp, dst_clu, dst_proc;
    logic [3:0] my_tile, dst_tile;

    logic       lv, sv, ld, sd;
    logic [4:0] lp, sp;
    logic [3:0] lt, st, lc, sc;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtr_route_sel #(.LARGE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_from_grp(in_from_grp),
        .my_grp(my_grp), .my_clu(my_clu), .my_tile(my_tile),
        .dst_grp(dst_grp), .dst_clu(dst_clu), .dst_tile(dst_tile),
        .dst_proc(dst_proc),
        .out_valid(lv), .out_port(lp), .out_tile(lt), .out_vc(lc),
        .out_drop(ld)
    );

    rtr_route_sel #(.LARGE(1'b0)) dut_small_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_from_grp(in_from_grp),
        .my_grp(my_grp), .my_clu(my_clu), .my_tile(my_tile),
        .dst_grp(dst_grp), .dst_clu(dst_clu), .dst_tile(dst_tile),
        .dst_proc(dst_proc),
        .out_valid(sv), .out_port(sp), .out_tile(st), .out_vc(sc),
        .out_drop(sd)
    );

    // Gateway tile for cluster s toward cluster d, from the R4 table.
    function automatic int gw_tile(input int s, input int d);
        int corner;
        case (s * 4 + d)
            1, 14, 8:  corner = 1;
            2, 4, 13:  corner = 0;
            default:   corner = 2;
        endcase
        if (s == 2 && d == 3) corner = 0;
        if (s == 3 && d == 2) corner = 1;
        if (s == 1 && d == 3) corner = 1;
        if (s == 3 && d == 1) corner = 0;
        return (corner == 0) ? 0 : (corner == 1) ? 3 : 12;
    endfunction

    function automatic int shport(input int tgt, input int own);
        return (tgt < own) ? 4 + tgt : 3 + tgt;
    endfunction

    function automatic void expect_route(
        input bit L, input int mg, input int mc, input int mt,
        input int dg, input int dc, input int dt, input int dp, input bit fg,
        output int port, output int tile, output int vc, output bit drop,
        output string tag);
        int dir, ct;
        dir  = L ? (mg ^ dg) : 0;
        drop = 1'b0;
        if (L && fg && dir == 0 && dc != mc) begin
            port = 0; tile = 0; vc = 0; drop = 1'b1; tag = "R9";
        end else if (dir != 0) begin
            ct   = (dir == 2) ? 0 : (dir == 1) ? 3 : 12;
            port = (mt == ct) ? 20 : shport(ct, mt);
            tile = ct;
            vc   = (dir == 2) ? 2 : (dir == 1) ? 4 : 8;
            tag  = "R7";
        end else if (dc != mc) begin
            ct = gw_tile(mc, dc);
            if (mt == ct) begin
                port = 19; tile = gw_tile(dc, mc); vc = L ? 1 : 12; tag = "R5";
            end else begin
                port = shport(ct, mt); tile = ct; vc = L ? 1 : 3; tag = "R4";
            end
        end else if (dt == mt) begin
            port = dp; tile = mt; vc = 0; tag = "R2";
        end else begin
            port = shport(dt, mt); tile = dt; vc = L ? 1 : 3; tag = "R3";
        end
    endfunction

    task automatic check_one(input bit L, input string tag, input int act,
                             input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s layout=%0d %s actual=%0d expected=%0d",
                     tag, what, L ? 1024 : 256, "", act, exp);
        end
    endtask

    task automatic run_vec(input int mg, input int mc, input int mt,
                           input int dg, input int dc, input int dt,
                           input int dp, input bit fg);
        int ep, et, ev;
        bit ed;
        string tg;
        in_valid    = 1'b1;
        in_from_grp = fg;
        my_grp  = 2'(mg);  my_clu  = 2'(mc);  my_tile  = 4'(mt);
        dst_grp = 2'(dg);  dst_clu = 2'(dc);  dst_tile = 4'(dt);
        dst_proc = 2'(dp);
        @(negedge clk);
        expect_route(1'b1, mg, mc, mt, dg, dc, dt, dp, fg, ep, et, ev, ed, tg);
        check_one(1'b1, "R1", int'(lv), 1, "valid");
        check_one(1'b1, tg, int'(lp), ep, "port");
        check_one(1'b1, tg, int'(lt), et, "tile");
        check_one(1'b1, (tg == "R9") ? "R9" : "R8", int'(lc), ev, "vc");
        check_one(1'b1, "R9", int'(ld), int'(ed), "drop");
        expect_route(1'b0, mg, mc, mt, dg, dc, dt, dp, fg, ep, et, ev, ed, tg);
        check_one(1'b0, "R1", int'(sv), 1, "valid");
        check_one(1'b0, tg, int'(sp), ep, "port");
        check_one(1'b0, tg, int'(st), et, "tile");
        check_one(1'b0, "R6", int'(sc), ev, "vc");
        check_one(1'b0, "R6", int'(sd), 0, "drop");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b0; in_from_grp = 1'b0;
        my_grp = '0; my_clu = '0; my_tile = '0;
        dst_grp = '0; dst_clu = '0; dst_tile = '0; dst_proc = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_one(1'b1, "R1", int'({lv, lp, lt, lc, ld}), 0, "reset");
        check_one(1'b0, "R1", int'({sv, sp, st, sc, sd}), 0, "reset");
        rst = 1'b0;

        // R2 eject, R3 shared below and above own tile
        run_vec(1, 2, 5, 1, 2, 5, 3, 1'b0);
        run_vec(0, 0, 5, 0, 0, 2, 0, 1'b0);
        run_vec(0, 0, 5, 0, 0, 15, 0, 1'b0);
        run_vec(0, 0, 0, 0, 0, 15, 1, 1'b0);
        // R4 R5 every ordered cluster pair from gateway and from a plain tile
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 4; d++) begin
                if (s != d) begin
                    run_vec(2, s, gw_tile(s, d), 2, d, 7, 1, 1'b0);
                    run_vec(2, s, 6, 2, d, 7, 1, 1'b0);
                end
            end
        end
        // R7 R8 each direction, at exit corner and elsewhere
        for (int dg = 1; dg < 4; dg++) begin
            run_vec(0, 1, 0, dg, 3, 9, 2, 1'b0);
            run_vec(0, 1, 3, dg, 3, 9, 2, 1'b0);
            run_vec(0, 1, 12, dg, 3, 9, 2, 1'b0);
            run_vec(0, 1, 8, dg, 3, 9, 2, 1'b0);
        end
        // R9 multicast copy at wrong cluster, and at intended cluster
        run_vec(3, 1, 0, 3, 2, 9, 0, 1'b1);
        run_vec(3, 2, 0, 3, 2, 9, 0, 1'b1);
        run_vec(3, 2, 9, 3, 2, 9, 2, 1'b1);
        // R6 group fields ignored by the small layout
        run_vec(1, 0, 3, 2, 1, 4, 0, 1'b1);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            int mg, dg;
            mg = $urandom_range(3);
            dg = ($urandom_range(3) == 0) ? $urandom_range(3) : mg;
            run_vec(mg, $urandom_range(3), $urandom_range(15),
                    dg, $urandom_range(3), $urandom_range(15),
                    $urandom_range(3), ($urandom_range(3) == 0));
        end

        // R1 idle follows
        in_valid = 1'b0;
        @(negedge clk);
        check_one(1'b1, "R1", int'(lv), 0, "idle valid");
        check_one(1'b0, "R1", int'(sv), 0, "idle valid");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule